// File: doc/BRIEF.md
# System Clock Select and Warm-Up Controller

This block sets the pace of a microcontroller core. It does not gate real clocks. It produces a single system-clock enable, `sys_ce`, in the main-clock domain. That enable pulses at the main rate divided by 2, 4, 8, 16 or 32, or once every second sub-clock tick. Sub-clock ticks arrive already synchronized, as a one-cycle enable. Software reaches the block through an 8-bit control register on a plain write strobe with a combinational read-back. The register holds a change-enable flag, a main-oscillator-halt flag, a 3-bit rate selection and a 2-bit warm-up selection.

Writing a new rate does not change the running rate. The written selection waits until the core asks to stop with the change-enable flag set, and is then copied into the active selection. While stopped, the enable stays low. A wake-up request starts a warm-up count, whose length comes from the register, before the enable resumes.

The warm-up is skipped in one case: the main oscillator is flagged as halted and the sub-clock is the active source. The warm-up lengths keep their power-of-two ratios, but the longest is scaled down by a parameter.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `warm_busy` and `halted` are 0, and `sys_ce` pulses once every 32 cycles.
- R2: A write stores bits 7:3 and 1:0 of `bus_wdata`, which read back unchanged on `bus_rdata`. Bit 2 (reserved) always reads 0.
- R3: Once applied, rate code (bits 5:3) 000/001/010/011/100 gives one `sys_ce` pulse every 32/16/8/4/2 cycles.
- R4: Once applied, rate code 111 gives one `sys_ce` pulse for every second `sub_tick` pulse.
- R5: A written rate code does not change `sys_ce` until a `stop_req` is accepted while bit 7 (change enable) is 1. A stop with bit 7 at 0 keeps the previous rate.
- R6: A stop with reserved rate code 101 or 110 keeps the previous rate, and the field still reads back as written.
- R7: A `stop_req` accepted while running raises `halted` from the next cycle and holds `sys_ce` low until a wake-up.
- R8: A `wake_req` while halted holds `warm_busy` high, with `sys_ce` low, for exactly 2^(WARM_LOG_MAX - w) cycles, where w is bits 1:0. With the defaults, codes 00/01/10/11 give 256/128/64/32 cycles.
- R9: A `wake_req` while running is ignored: `halted` and `warm_busy` stay 0 and the rate is unchanged.
- R10: While bit 6 (main-oscillator halt) is 1, `sys_ce` follows the sub-clock path (every second `sub_tick`), whatever the active rate.
- R11: A wake-up with bit 6 at 1 and active code 111 skips warm-up: `warm_busy` stays 0 and `sys_ce` resumes at the sub-clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read-back |
| sub_tick | input | 1 | Synchronized sub-clock tick enable |
| stop_req | input | 1 | Stop request pulse from the core |
| wake_req | input | 1 | Wake-up request pulse |
| sys_ce | output | 1 | System-clock enable |
| warm_busy | output | 1 | Warm-up count in progress |
| halted | output | 1 | Block is in the stopped state |

## Verification
A wrong active selection is visible at the ports: the spacing of `sys_ce` pulses, measured between two pulses, changes within at most 32 cycles of running. A corrupted power state shows up one cycle after the stop or wake pulse as a wrong `halted` or `warm_busy` level. A wrong warm-up length shows up as a `warm_busy` pulse of the wrong width, which is counted exactly. A leaked pending selection shows up as a rate change after a stop that should have kept the old rate.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;

  // number of divide-by-two stages behind main/2
  localparam int unsigned MAIN_DIV_STAGES = 5;
  localparam int unsigned TAP_W = $clog2(MAIN_DIV_STAGES + 1);
  localparam logic [2:0]  SEL_SUB = 3'b111;

  typedef enum logic [1:0] {ST_RUN, ST_STOP, ST_WARM} pwr_state_t;

  typedef struct packed {
    logic       chg_en;
    logic       osc_halt;
    logic [2:0] rate;
    logic       rsvd;
    logic [1:0] warm;
  } ctl_reg_t;

  function automatic logic rate_is_legal(input logic [2:0] code);
    return !(code == 3'b101 || code == 3'b110);
  endfunction

  // log2 of the main divisor for a rate code; sub and reserved map to 1
  function automatic logic [TAP_W-1:0] rate_tap(input logic [2:0] code);
    logic [TAP_W-1:0] t;
    case (code)
      3'b000:  t = TAP_W'(MAIN_DIV_STAGES);
      3'b001:  t = TAP_W'(MAIN_DIV_STAGES - 1);
      3'b010:  t = TAP_W'(MAIN_DIV_STAGES - 2);
      3'b011:  t = TAP_W'(MAIN_DIV_STAGES - 3);
      default: t = TAP_W'(1);
    endcase
    return t;
  endfunction

  // warm-up cycles: longest for code 0, halving per step
  function automatic int unsigned warm_cycles(input logic [1:0] code,
                                              input int unsigned log_max);
    return 32'd1 << (log_max - 32'(code));
  endfunction

endpackage

// File: rtl/sysclk_regs.sv
`timescale 1ns/1ps
module sysclk_regs
  import sysclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  input  logic       stop_event,
  output ctl_reg_t   ctl,
  output logic [2:0] active_rate,
  output logic [7:0] bus_rdata
);

  logic apply_rate;
  assign apply_rate = stop_event && ctl.chg_en && rate_is_legal(ctl.rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (bus_we) begin
      ctl <= ctl_reg_t'({bus_wdata[7:3], 1'b0, bus_wdata[1:0]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_rate <= 3'b000;
    end else if (apply_rate) begin
      active_rate <= ctl.rate;
    end
  end

  assign bus_rdata = ctl;

  // R5: the running rate only moves on an enabled stop
  assert_rate_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_event && ctl.chg_en) |=> $stable(active_rate));

  // R6: reserved codes never become active
  assert_reserved_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_event && !rate_is_legal(ctl.rate)) |=> $stable(active_rate));

  assert_active_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rate_is_legal(active_rate));

endmodule

// File: rtl/sysclk_divider.sv
`timescale 1ns/1ps
module sysclk_divider
  import sysclk_pkg::*;
#(
  parameter int unsigned STAGES = MAIN_DIV_STAGES,
  localparam int unsigned LW = $clog2(STAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          use_sub,
  input  logic          sub_tick,
  input  logic [LW-1:0] tap_sel,
  output logic          sys_ce
);

  logic [STAGES-1:0] chain;
  logic [STAGES:0]   taps;
  logic              sub_phase;
  logic              main_ce;
  logic              sub_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain + 1'b1;
  end

  // tap k fires once every 2^k cycles
  assign taps[0] = 1'b1;
  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    assign taps[k] = &chain[k-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sub_phase <= 1'b0;
    else if (sub_tick) sub_phase <= ~sub_phase;
  end

  assign main_ce = taps[tap_sel];
  assign sub_ce  = sub_tick && sub_phase;
  assign sys_ce  = run_en && (use_sub ? sub_ce : main_ce);

  // R4: on the sub path every enable coincides with a sub tick
  assert_sub_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ce && use_sub) |-> sub_tick);

  // R3: divisors of four or more never give back-to-back enables
  assert_main_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ce && !use_sub && tap_sel > LW'(1)) |=> (!sys_ce || use_sub));

endmodule

// File: rtl/sysclk_power_fsm.sv
`timescale 1ns/1ps
module sysclk_power_fsm
  import sysclk_pkg::*;
#(
  parameter int unsigned WARM_LOG_MAX = 8,
  localparam int unsigned CW = WARM_LOG_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wake_req,
  input  logic [1:0] warm_code,
  input  logic       skip_warm,
  output logic       run_en,
  output logic       halted,
  output logic       warm_busy,
  output logic       stop_event
);

  pwr_state_t    state, state_nx;
  logic [CW-1:0] warm_cnt;
  logic          wake_event;
  logic          warm_done;

  assign stop_event = (state == ST_RUN) && stop_req;
  assign wake_event = (state == ST_STOP) && wake_req;
  assign warm_done  = (state == ST_WARM) && (warm_cnt == '0);

  always_comb begin
    state_nx = state;
    case (state)
      ST_RUN:  if (stop_req) state_nx = ST_STOP;
      ST_STOP: if (wake_req) state_nx = skip_warm ? ST_RUN : ST_WARM;
      ST_WARM: if (warm_done) state_nx = ST_RUN;
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0;
    end else if (wake_event) begin
      warm_cnt <= CW'(warm_cycles(warm_code, WARM_LOG_MAX) - 1);
    end else if (state == ST_WARM && warm_cnt != '0) begin
      warm_cnt <= warm_cnt - 1'b1;
    end
  end

  assign run_en    = (state == ST_RUN);
  assign halted    = (state == ST_STOP);
  assign warm_busy = (state == ST_WARM);

  // R7: an accepted stop halts from the next cycle
  assert_stop_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_event |=> halted);

  // R8: a normal wake-up enters warm-up
  assert_busy_after_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_event && !skip_warm) |=> warm_busy);

  assert_warm_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warm_done |=> run_en);

  // R9: wake-up while running changes nothing
  assert_wake_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && wake_req && !stop_req) |=> run_en);

  // R11: sub-clock wake-up bypasses warm-up
  assert_skip_warm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_event && skip_warm) |=> (run_en && !warm_busy));

endmodule

// File: rtl/sysclk_ctrl.sv
`timescale 1ns/1ps
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned WARM_LOG_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sub_tick,
  input  logic       stop_req,
  input  logic       wake_req,
  output logic       sys_ce,
  output logic       warm_busy,
  output logic       halted
);

  ctl_reg_t         ctl;
  logic [2:0]       active_rate;
  logic             stop_event;
  logic             run_en;
  logic             use_sub;
  logic             skip_warm;
  logic [TAP_W-1:0] tap_sel;

  assign use_sub   = ctl.osc_halt || (active_rate == SEL_SUB);
  assign skip_warm = ctl.osc_halt && (active_rate == SEL_SUB);
  assign tap_sel   = rate_tap(active_rate);

  sysclk_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .stop_event  (stop_event),
    .ctl         (ctl),
    .active_rate (active_rate),
    .bus_rdata   (bus_rdata)
  );

  sysclk_power_fsm #(.WARM_LOG_MAX(WARM_LOG_MAX)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .wake_req   (wake_req),
    .warm_code  (ctl.warm),
    .skip_warm  (skip_warm),
    .run_en     (run_en),
    .halted     (halted),
    .warm_busy  (warm_busy),
    .stop_event (stop_event)
  );

  sysclk_divider #(.STAGES(MAIN_DIV_STAGES)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .use_sub  (use_sub),
    .sub_tick (sub_tick),
    .tap_sel  (tap_sel),
    .sys_ce   (sys_ce)
  );

  // R7: no enable leaves the block while stopped or warming up
  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || warm_busy) |-> !sys_ce);

  // R10: oscillator halt forces every enable onto a sub tick
  assert_halt_uses_sub_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.osc_halt && sys_ce) |-> sub_tick);

endmodule

// File: tb/test_sysclk_ctrl.sv
`timescale 1ns/1ps
module test_sysclk_ctrl;

  localparam int unsigned WLOG = 8;
  localparam int SUB_GAP = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sub_tick = 1'b0;
  logic       stop_req = 1'b0;
  logic       wake_req = 1'b0;
  logic       sys_ce;
  logic       warm_busy;
  logic       halted;

  always #2.5 clk = ~clk;

  sysclk_ctrl #(.WARM_LOG_MAX(WLOG)) i_sysclk_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sub_tick(sub_tick), .stop_req(stop_req),
    .wake_req(wake_req), .sys_ce(sys_ce), .warm_busy(warm_busy), .halted(halted)
  );

  // scoreboard
  typedef struct { string tag; int val; } item_t;
  item_t exp_q[$];
  int    act_q[$];
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;

  task automatic expect_item(input string tag, input int val);
    item_t it;
    it.tag = tag;
    it.val = val;
    exp_q.push_back(it);
  endtask

  task automatic observe(input int val);
    act_q.push_back(val);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        item_t e;
        int    a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        compared++;
        if (a != e.val) begin
          mismatched++;
          $display("FAIL %s: actual %0d expected %0d", e.tag, a, e.val);
        end
      end
    end
  end

  // sub-clock ticks every SUB_GAP cycles
  initial begin
    forever begin
      repeat (SUB_GAP - 1) @(negedge clk);
      sub_tick = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0;
    end
  end

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b1;
    bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic measure_period(output int n);
    @(negedge clk);
    while (!sys_ce) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_ce);
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic do_wake(output int busy_n, output int ce_seen);
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    busy_n = 0;
    ce_seen = 0;
    while (warm_busy) begin
      busy_n++;
      if (sys_ce) ce_seen++;
      @(negedge clk);
    end
  endtask

  function automatic int main_div(input int code);
    return 32 >> code;
  endfunction

  function automatic int warm_len(input int code);
    return 2 ** (WLOG - code);
  endfunction

  task automatic stop_wake_check(input string tag, input int wcode);
    int b, c;
    do_stop();
    expect_item({tag, " halted after stop"}, 1);
    observe(int'(halted));
    do_wake(b, c);
    expect_item({tag, " warm-up length"}, warm_len(wcode));
    observe(b);
    expect_item({tag, " no enable in warm-up"}, 0);
    observe(c);
  endtask

  task automatic check_period(input string tag, input int exp_n);
    int n;
    measure_period(n);
    expect_item(tag, exp_n);
    observe(n);
  endtask

  initial begin
    int n, b, c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_item("R1 reset readback", 0);  observe(int'(bus_rdata));
    expect_item("R1 reset busy", 0);      observe(int'(warm_busy));
    expect_item("R1 reset halted", 0);    observe(int'(halted));
    check_period("R1 reset period", 32);

    // R2 readback, reserved bit reads 0; R5 no change yet
    write_reg(8'h9D);
    @(negedge clk);
    expect_item("R2 readback", 8'h99);    observe(int'(bus_rdata));
    check_period("R5 pending rate not applied", 32);

    // R7 stop holds enable low
    do_stop();
    expect_item("R7 halted", 1);          observe(int'(halted));
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sys_ce) c++;
    end
    expect_item("R7 no enable while halted", 0); observe(c);
    expect_item("R7 still halted", 1);    observe(int'(halted));
    do_wake(b, c);
    expect_item("R8 warm-up code 01", warm_len(1)); observe(b);
    expect_item("R8 no enable in warm-up", 0);      observe(c);
    check_period("R3 rate 011", 4);

    // R9 wake while running
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    expect_item("R9 halted stays 0", 0);  observe(int'(halted));
    expect_item("R9 busy stays 0", 0);    observe(int'(warm_busy));
    check_period("R9 rate unchanged", 4);

    // R5 stop with change disabled
    write_reg(8'h23);
    stop_wake_check("R5 disabled stop", 3);
    check_period("R5 rate kept", 4);

    // R6 reserved rate code
    write_reg(8'hAA);
    @(negedge clk);
    expect_item("R6 reserved readback", 8'hAA); observe(int'(bus_rdata));
    stop_wake_check("R6 reserved stop", 2);
    check_period("R6 rate kept", 4);

    // R3 all main rates; R8 code 00 on the first
    for (int s = 0; s <= 4; s++) begin
      int w;
      w = (s == 0) ? 0 : 3;
      write_reg(8'(8'h80 | (s << 3) | w));
      stop_wake_check("R8 warm-up", w);
      check_period("R3 main rate", main_div(s));
    end

    // R10 oscillator halt forces sub path while main rate active
    write_reg(8'h60);
    check_period("R10 sub path under halt", 2 * SUB_GAP);
    write_reg(8'h23);
    check_period("R10 main path restored", 2);

    // R4 sub rate with warm-up
    write_reg(8'hBB);
    stop_wake_check("R4 sub select", 3);
    check_period("R4 sub rate", 2 * SUB_GAP);

    // R11 skip warm-up
    write_reg(8'hFB);
    @(negedge clk);
    expect_item("R2 readback full", 8'hFB); observe(int'(bus_rdata));
    do_stop();
    do_wake(b, c);
    expect_item("R11 no warm-up", 0);     observe(b);
    expect_item("R11 running", 0);        observe(int'(halted));
    n = 0;
    while (!sys_ce && n < 4 * SUB_GAP) begin
      @(negedge clk);
      n++;
    end
    expect_item("R11 enable resumes", 1); observe(int'(n <= 2 * SUB_GAP));
    check_period("R11 sub rate", 2 * SUB_GAP);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule